// File: doc/BRIEF.md
# Serial Frame Receiver with Status-Tagged Receive Queue

This block recovers asynchronous serial characters from a single input line. It runs on the system clock and uses a baud tick input that pulses sixteen times per bit period. A character starts with a low start bit. Five to eight data bits follow, least significant first. Then comes an optional parity bit and one or two stop bits. The line passes through a two-flop synchronizer, and each bit is decided by a three-sample majority vote taken around the middle of the bit.

Every completed character goes into an eight-entry queue. The data and its own error flags (break, framing, parity) sit in one entry, so a single read of the output word returns the character and its status together. A not-empty output tells the consumer that an entry is waiting. A one-cycle pop strobe removes the entry at the head. If a character completes while the queue is full and no slot is freed in that cycle, the character is dropped and a sticky overrun flag is raised. A write-one-to-clear strobe clears that flag.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset the queue is empty, `rx_avail` is 0, `rx_word` is all zeros and `ovr` is 0.
- R2: The data bit count is 5 + `len_sel` (0..3 gives 5..8). Bits arrive least significant first and land in `rx_word[7:0]`; unused upper data bits read 0.
- R3: A falling edge starts a frame only if the line is still low at the middle tick of the start bit. Otherwise nothing is stored.
- R4: Each bit is the majority of the synchronized samples at ticks 7, 8 and 9 of its sixteen, so a disturbance that spans only one of those samples does not change the bit.
- R5: `par_mode` selects the parity: 0 none, 1 even, 2 odd (3 behaves as none). After the whole frame is in, `rx_word[10]` is 1 when the received parity bit does not match the parity of the data bits. With no parity it is always 0.
- R6: `rx_word[9]` (framing) is 1 when the first stop bit is sampled low.
- R7: With `two_stop` set, only the first stop bit is checked. A low second stop bit raises no framing error and does not start a new character.
- R8: `rx_word[8]` (break) is 1 when every sampled bit of the frame is 0, stop bit included. Such an entry also has its framing bit set.
- R9: The queue holds 8 entries in arrival order. `rx_avail` is 1 whenever it is not empty. `pop` removes the head, and a pop while empty has no effect. `rx_word` reads 0 when the queue is empty, and `rx_word[31:11]` is always 0.
- R10: A character that completes while the queue is full, with no pop in that cycle, is discarded. The stored entries are left unchanged and `ovr` is set, and it stays set.
- R11: `ovr_clr` clears `ovr`. When an overrun occurs in the same cycle as `ovr_clr`, the flag ends up set.
- R12: A character that completes while the queue is full, in the same cycle as a pop, is stored and does not set `ovr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| len_sel | input | 2 | Data bit count minus five |
| two_stop | input | 1 | 1 selects two stop bits |
| par_mode | input | 2 | Parity mode: 0 none, 1 even, 2 odd |
| pop | input | 1 | Remove the head entry |
| ovr_clr | input | 1 | Write-one-to-clear for the overrun flag |
| rx_word | output | 32 | Head entry: data [7:0], break [8], framing [9], parity [10], rest zero |
| rx_avail | output | 1 | Queue not empty |
| ovr | output | 1 | Sticky overrun flag |

## Verification
Two events can land on the same clock edge: the completion of a character into a full queue, and a consumer pop or an overrun clear. The bench knows the exact edge at which each character completes, because it sets the stop-bit vote from its own tick count. It pulses `pop` on that edge to show that the new character is kept without an overrun. It pulses `ovr_clr` on that edge to show that the flag stays set. A behavioural queue model is updated edge by edge and compared with `rx_avail`, `rx_word` and `ovr` after every clock. Dropped characters, lost entries and a wrong flag order therefore show up in the cycle they occur.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int OS    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxd,
  input  logic        baud_tick,
  input  logic [1:0]  len_sel,
  input  logic        two_stop,
  input  logic [1:0]  par_mode,
  input  logic        pop,
  input  logic        ovr_clr,
  output logic [31:0] rx_word,
  output logic        rx_avail,
  output logic        ovr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(OS);
  localparam int MID = OS / 2;
  localparam logic [CW-1:0] C_LO  = CW'(MID - 1);
  localparam logic [CW-1:0] C_MID = CW'(MID);
  localparam logic [CW-1:0] C_HI  = CW'(MID + 1);
  localparam logic [CW-1:0] C_END = CW'(OS - 1);
  localparam logic [AW:0]   FULLV = (AW+1)'(DEPTH);

  typedef enum logic [2:0] {IDLE, START, BITS, STOP2, HOLD} st_t;

  st_t st;
  logic s1, s2;
  logic [CW-1:0] cnt;
  logic [3:0] idx;
  logic [7:0] dat;
  logic pbit, seen1, v_lo, v_mid, second;

  logic [10:0] mem [DEPTH];
  logic [AW:0] wp, rp;

  wire par_on = (par_mode == 2'd1) || (par_mode == 2'd2);
  wire [3:0] nbits = 4'd5 + {2'b00, len_sel};
  wire [3:0] last  = nbits + {3'b000, par_on};
  wire vote = (v_lo & v_mid) | (v_lo & s2) | (v_mid & s2);
  wire done = (st == BITS) && baud_tick && (cnt == C_HI) && (idx == last);
  wire perr = par_on && ((^dat) ^ pbit ^ (par_mode == 2'd2));
  wire brk  = !(seen1 | vote);
  wire [10:0] wdata = {perr, !vote, brk, dat};

  wire [AW:0] fill = wp - rp;
  wire empty  = (wp == rp);
  wire full   = (fill == FULLV);
  wire pop_ok = pop && !empty;
  wire wr_en  = done && (!full || pop_ok);
  wire ovf    = done && full && !pop_ok;

  assign rx_avail = !empty;
  assign rx_word  = {21'b0, empty ? 11'b0 : mem[rp[AW-1:0]]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      cnt <= '0;
      idx <= '0;
      dat <= '0;
      pbit <= 1'b0;
      seen1 <= 1'b0;
      v_lo <= 1'b0;
      v_mid <= 1'b0;
      second <= 1'b0;
    end else if (baud_tick) begin
      case (st)
        IDLE: if (!s2) begin
          st  <= START;
          cnt <= CW'(1);
        end
        START: begin
          cnt <= cnt + 1'b1;
          if (cnt == C_MID && s2) st <= IDLE;
          else if (cnt == C_END) begin
            st <= BITS;
            cnt <= '0;
            idx <= '0;
            dat <= '0;
            seen1 <= 1'b0;
          end
        end
        BITS: begin
          cnt <= (cnt == C_END) ? '0 : cnt + 1'b1;
          if (cnt == C_LO)  v_lo  <= s2;
          if (cnt == C_MID) v_mid <= s2;
          if (cnt == C_HI) begin
            seen1 <= seen1 | vote;
            if (idx < nbits) dat[idx[2:0]] <= vote;
            else if (idx == nbits) pbit <= vote;
            if (idx == last) begin
              st <= two_stop ? STOP2 : HOLD;
              second <= 1'b0;
            end
          end
          if (cnt == C_END) idx <= idx + 1'b1;
        end
        STOP2: begin
          cnt <= (cnt == C_END) ? '0 : cnt + 1'b1;
          if (cnt == C_END) begin
            if (second) st <= HOLD;
            second <= 1'b1;
          end
        end
        HOLD: if (s2) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      ovr <= 1'b0;
    end else begin
      if (wr_en)  wp <= wp + 1'b1;
      if (pop_ok) rp <= rp + 1'b1;
      if (ovf) ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
    end
  end

  // R10
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full && !pop) |=> (wp == $past(wp)));

  // R8
  brk_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[8]) |-> wdata[9]);

  // R5
  nopar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && par_mode == 2'd0) |-> !wdata[10]);

  // R9
  pop_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !wr_en) |=> (fill == $past(fill) - 1'b1));

  // R11
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(done && full));

  // R3
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == START && baud_tick && cnt == C_MID && s2) |=> (st == IDLE && !wr_en));
endmodule

// File: tb/sim_uart_rx_fifo.sv
module sim_uart_rx_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic baud_tick = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic two_stop = 1'b0;
  logic [1:0] par_mode = 2'd0;
  logic pop = 1'b0;
  logic ovr_clr = 1'b0;
  logic [31:0] rx_word;
  logic rx_avail;
  logic ovr;

  always #4 clk = ~clk;

  uart_rx_fifo u0 (.clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
    .len_sel(len_sel), .two_stop(two_stop), .par_mode(par_mode), .pop(pop),
    .ovr_clr(ovr_clr), .rx_word(rx_word), .rx_avail(rx_avail), .ovr(ovr));

  int total = 0;
  int bad = 0;
  int ph = 0;
  string cur_req = "R1";
  logic [10:0] q[$];
  logic ovr_m = 1'b0;
  logic line = 1'b1;
  logic pop_r = 1'b0;
  logic clr_r = 1'b0;

  task automatic compare();
    logic [31:0] ew;
    ew = (q.size() > 0) ? {21'b0, q[0]} : 32'b0;
    total++;
    if (rx_avail !== (q.size() > 0) || rx_word !== ew || ovr !== ovr_m) begin
      bad++;
      $display("FAIL %s: avail=%0b word=%h ovr=%0b expected avail=%0b word=%h ovr=%0b",
               cur_req, rx_avail, rx_word, ovr, q.size() > 0, ew, ovr_m);
    end
  endtask

  task automatic step(input bit do_push, input logic [10:0] ent);
    bit fullb, popped, ovf;
    @(negedge clk);
    compare();
    baud_tick = (ph % 4 == 0);
    ph++;
    rxd = line;
    pop = pop_r;
    ovr_clr = clr_r;
    fullb = (q.size() == 8);
    popped = pop_r && q.size() > 0;
    ovf = 1'b0;
    if (popped) void'(q.pop_front());
    if (do_push) begin
      if (!fullb || popped) q.push_back(ent);
      else ovf = 1'b1;
    end
    if (ovf) ovr_m = 1'b1;
    else if (clr_r) ovr_m = 1'b0;
  endtask

  task automatic idle(input int n);
    line = 1'b1;
    for (int i = 0; i < n; i++) step(1'b0, 11'b0);
  endtask

  task automatic align();
    while (ph % 4 != 0) step(1'b0, 11'b0);
  endtask

  task automatic send(input logic [7:0] data, input int nb, input int par, input bit pflip,
                      input bit stop1, input bit stop2, input bit glitch,
                      input int pop_s, input int clr_s);
    bit bits[$];
    logic [7:0] d;
    bit pb, paron, perr, ferr, brk;
    int k;
    logic [10:0] ent;
    len_sel = 2'(nb - 5);
    par_mode = 2'(par);
    d = data & 8'((1 << nb) - 1);
    paron = (par == 1 || par == 2);
    pb = ($countones(d) % 2 == 1) ^ (par == 2) ^ pflip;
    perr = paron && pflip;
    ferr = !stop1;
    brk = (d == 0) && (!paron || !pb) && !stop1;
    ent = {perr, ferr, brk, d};
    bits.push_back(1'b0);
    for (int i = 0; i < nb; i++) bits.push_back(d[i]);
    if (paron) bits.push_back(pb);
    k = bits.size();
    bits.push_back(stop1);
    if (two_stop) bits.push_back(stop2);
    align();
    for (int b = 0; b < bits.size(); b++) begin
      for (int j = 0; j < 64; j++) begin
        int s;
        s = b * 64 + j;
        line = bits[b];
        if (glitch && b == 1 && j >= 29 && j <= 31) line = !bits[b];
        pop_r = (s == pop_s);
        clr_r = (s == clr_s);
        step(s == 64 * k + 40, ent);
      end
    end
    pop_r = 1'b0;
    clr_r = 1'b0;
    idle(80);
  endtask

  task automatic pop_once();
    pop_r = 1'b1;
    step(1'b0, 11'b0);
    pop_r = 1'b0;
    idle(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    idle(8);

    cur_req = "R2";
    send(8'hA5, 8, 0, 0, 1, 1, 0, -1, -1);
    send(8'h3C, 8, 0, 0, 1, 1, 0, -1, -1);
    send(8'h16, 5, 0, 0, 1, 1, 0, -1, -1);
    pop_once(); pop_once(); pop_once();

    cur_req = "R4";
    send(8'h5A, 8, 0, 0, 1, 1, 1, -1, -1);
    send(8'h01, 6, 0, 0, 1, 1, 1, -1, -1);
    pop_once(); pop_once();

    cur_req = "R5";
    send(8'h6B, 7, 1, 0, 1, 1, 0, -1, -1);
    send(8'h6B, 7, 1, 1, 1, 1, 0, -1, -1);
    send(8'h13, 5, 2, 0, 1, 1, 0, -1, -1);
    send(8'h13, 5, 2, 1, 1, 1, 0, -1, -1);
    send(8'hF0, 8, 0, 0, 1, 1, 0, -1, -1);
    pop_once(); pop_once(); pop_once(); pop_once(); pop_once();

    cur_req = "R6";
    send(8'h81, 8, 0, 0, 0, 1, 0, -1, -1);
    cur_req = "R8";
    send(8'h00, 8, 0, 0, 0, 0, 0, -1, -1);
    send(8'h00, 8, 1, 0, 0, 0, 0, -1, -1);
    pop_once(); pop_once(); pop_once();

    cur_req = "R7";
    two_stop = 1'b1;
    send(8'hC3, 8, 0, 0, 1, 0, 0, -1, -1);
    send(8'h4E, 8, 1, 0, 1, 1, 0, -1, -1);
    two_stop = 1'b0;
    pop_once(); pop_once();

    cur_req = "R3";
    align();
    line = 1'b0;
    for (int i = 0; i < 16; i++) step(1'b0, 11'b0);
    idle(120);

    cur_req = "R9";
    pop_once();
    for (int i = 0; i < 8; i++) send(8'(i * 17 + 3), 8, 0, 0, 1, 1, 0, -1, -1);
    cur_req = "R12";
    send(8'h99, 8, 0, 0, 1, 1, 0, 64 * 9 + 40, -1);
    cur_req = "R10";
    send(8'h77, 8, 0, 0, 1, 1, 0, -1, -1);
    idle(20);
    cur_req = "R11";
    clr_r = 1'b1; step(1'b0, 11'b0); clr_r = 1'b0;
    idle(5);
    send(8'h55, 8, 0, 0, 1, 1, 0, -1, 64 * 9 + 40);
    idle(10);
    clr_r = 1'b1; step(1'b0, 11'b0); clr_r = 1'b0;
    cur_req = "R9";
    for (int i = 0; i < 9; i++) pop_once();
    idle(10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule